// File: doc/BRIEF.md
# Reservation Station Bank with Tag-Snooping Wakeup

This block holds a handful of instructions that wait for one functional unit. Each slot stores an operation code and two source operands. A source is either a captured value or the tag of the producer that will compute it. A producer tag of zero means the value is already present. Every entry receives a nonzero tag equal to its slot index plus one, so zero is never handed out.

Upstream issue logic offers one instruction per cycle. The bank places it in the lowest-numbered free slot and reports the tag it assigned. When no slot is free, the bank raises a full flag and the offered instruction is not taken. Every cycle the bank watches a shared result bus. Any waiting operand whose producer tag matches the broadcast takes the broadcast value and marks itself present. An instruction offered in the same cycle as the broadcast it waits for captures that value on entry.

Each cycle the bank hands at most one entry with both operands present to the unit. When several entries are ready, it picks the one issued earliest. A dispatched slot is free from the next cycle on.

Top module: `rsv_bank`

## Requirements
- R1: After reset no slot is busy: `iss_full` is 0, `dsp_valid` is 0 and `iss_tag` is 1.
- R2: An accepted issue lands in the lowest-numbered free slot; `iss_tag` shows that slot's tag (index + 1, never 0), and the same tag appears on `dsp_tag` when the entry dispatches.
- R3: An instruction issued with both producer tags zero is offered on the dispatch port in the cycle after its issue edge, with its own op code and operand values.
- R4: When every slot is busy, `iss_full` is 1 and an offered instruction is dropped: it never appears on the dispatch port.
- R5: A result-bus broadcast (`cdb_valid` = 1) whose tag equals a waiting producer tag writes the bus value into that operand; the entry, if now complete, dispatches in the cycle after the broadcast edge.
- R6: An entry with either producer tag nonzero is never dispatched.
- R7: Among several ready entries, the one issued earliest dispatches first, one entry per cycle.
- R8: An issue whose producer tag equals the tag broadcast in that same cycle stores the broadcast value in place of the offered operand value.
- R9: A dispatched slot is free in the following cycle, so `iss_full` drops and that slot becomes allocatable.
- R10: A broadcast carrying tag 0 changes no entry.
- R11: A broadcast whose tag no entry waits for changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_op | input | OP_W | Operation code of the offered instruction |
| iss_vj | input | DATA_W | First operand value (used when `iss_qj` is 0) |
| iss_qj | input | TAG_W | Producer tag of first operand, 0 if present |
| iss_vk | input | DATA_W | Second operand value (used when `iss_qk` is 0) |
| iss_qk | input | TAG_W | Producer tag of second operand, 0 if present |
| iss_full | output | 1 | No free slot; the offer is not accepted |
| iss_tag | output | TAG_W | Tag the offered instruction receives if accepted |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the producer on the result bus |
| cdb_value | input | DATA_W | Result value on the bus |
| dsp_valid | output | 1 | An entry is sent to the unit this cycle |
| dsp_op | output | OP_W | Operation code of the sent entry |
| dsp_vj | output | DATA_W | First operand of the sent entry |
| dsp_vk | output | DATA_W | Second operand of the sent entry |
| dsp_tag | output | TAG_W | Tag of the sent entry |

## Verification
The slot state is registered, and the dispatch port and full flag are decoded from it without further delay. An issue or a broadcast is therefore seen at the dispatch port in the cycle after the edge that takes it. A slot freed by a dispatch reads as free one cycle after the dispatch appears. The bench drives every input on the falling edge and samples one time unit after the next rising edge, where each expected change is due. Ordering is checked by holding several entries on one producer tag, releasing them with a single broadcast and reading one dispatch per following cycle in issue order.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  localparam int unsigned TAG_NONE = 0;

  // Tag owned by a slot: its index plus one, so zero stays free.
  function automatic int unsigned slot_tag(input int unsigned idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/rsv_entry.sv
module rsv_entry #(
  parameter int unsigned OP_W   = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              release_i,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_vj,
  input  logic [TAG_W-1:0]  in_qj,
  input  logic [DATA_W-1:0] in_vk,
  input  logic [TAG_W-1:0]  in_qk,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk,
  output logic [TAG_W-1:0]  qj,
  output logic [TAG_W-1:0]  qk
);

  function automatic logic snoop_hit(input logic [TAG_W-1:0] q,
                                     input logic             bv,
                                     input logic [TAG_W-1:0] bt);
    return bv && (q != TAG_W'(rsv_pkg::TAG_NONE)) && (q == bt);
  endfunction

  logic hit_in_j, hit_in_k, hit_j, hit_k;

  assign hit_in_j = snoop_hit(in_qj, cdb_valid, cdb_tag);
  assign hit_in_k = snoop_hit(in_qk, cdb_valid, cdb_tag);
  assign hit_j    = busy && snoop_hit(qj, cdb_valid, cdb_tag);
  assign hit_k    = busy && snoop_hit(qk, cdb_valid, cdb_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      op   <= '0;
      vj   <= '0;
      vk   <= '0;
      qj   <= '0;
      qk   <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      op   <= in_op;
      vj   <= hit_in_j ? cdb_value : in_vj;
      qj   <= hit_in_j ? '0 : in_qj;
      vk   <= hit_in_k ? cdb_value : in_vk;
      qk   <= hit_in_k ? '0 : in_qk;
    end else begin
      if (release_i) begin
        busy <= 1'b0;
      end
      if (hit_j) begin
        vj <= cdb_value;
        qj <= '0;
      end
      if (hit_k) begin
        vk <= cdb_value;
        qk <= '0;
      end
    end
  end

  assign ready = busy && (qj == '0) && (qk == '0);

endmodule

// File: rtl/rsv_alloc.sv
module rsv_alloc #(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] busy_vec,
  output logic             any_free,
  output logic [N_ENT-1:0] pick_oh,
  output logic [IDX_W-1:0] pick_idx
);

  always_comb begin
    any_free = 1'b0;
    pick_oh  = '0;
    pick_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!busy_vec[i] && !any_free) begin
        any_free    = 1'b1;
        pick_oh[i]  = 1'b1;
        pick_idx    = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rsv_age_sel.sv
module rsv_age_sel #(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] alloc_oh,
  input  logic [N_ENT-1:0] busy_vec,
  input  logic [N_ENT-1:0] ready_vec,
  output logic             grant_valid,
  output logic [N_ENT-1:0] grant_oh,
  output logic [IDX_W-1:0] grant_idx
);

  // older_m[i][j] set: slot i was issued before slot j.
  logic [N_ENT-1:0] older_m [N_ENT];

  genvar gi;
  generate
    for (gi = 0; gi < N_ENT; gi++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          older_m[gi] <= '0;
        end else begin
          for (int j = 0; j < N_ENT; j++) begin
            if (alloc_oh[gi]) begin
              older_m[gi][j] <= 1'b0;
            end else if (alloc_oh[j]) begin
              older_m[gi][j] <= busy_vec[gi];
            end
          end
        end
      end
    end
  endgenerate

  always_comb begin
    grant_oh = '0;
    for (int i = 0; i < N_ENT; i++) begin
      grant_oh[i] = ready_vec[i];
      for (int j = 0; j < N_ENT; j++) begin
        if (j != i && ready_vec[j] && older_m[j][i]) begin
          grant_oh[i] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant_oh[i]) begin
        grant_idx = IDX_W'(i);
      end
    end
  end

  assign grant_valid = |grant_oh;

endmodule

// File: rtl/rsv_bank.sv
module rsv_bank #(
  parameter int unsigned N_ENT  = 4,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  output logic              iss_full,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              dsp_valid,
  output logic [OP_W-1:0]   dsp_op,
  output logic [DATA_W-1:0] dsp_vj,
  output logic [DATA_W-1:0] dsp_vk,
  output logic [TAG_W-1:0]  dsp_tag
);

  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  // Named internal events, also watched by the checker.
  logic [N_ENT-1:0]       busy_vec;
  logic [N_ENT-1:0]       ready_vec;
  logic [N_ENT-1:0]       pick_oh;
  logic [N_ENT-1:0]       alloc_oh;
  logic [N_ENT-1:0]       grant_oh;
  logic [N_ENT*TAG_W-1:0] qj_flat;
  logic [N_ENT*TAG_W-1:0] qk_flat;
  logic [IDX_W-1:0]       pick_idx;
  logic [IDX_W-1:0]       grant_idx;
  logic                   any_free;
  logic                   issue_fire;

  logic [OP_W-1:0]   op_a [N_ENT];
  logic [DATA_W-1:0] vj_a [N_ENT];
  logic [DATA_W-1:0] vk_a [N_ENT];
  logic [TAG_W-1:0]  qj_a [N_ENT];
  logic [TAG_W-1:0]  qk_a [N_ENT];

  rsv_alloc #(.N_ENT(N_ENT)) alloc_i (
    .busy_vec (busy_vec),
    .any_free (any_free),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx)
  );

  assign iss_full   = !any_free;
  assign issue_fire = iss_valid && any_free;
  assign alloc_oh   = issue_fire ? pick_oh : '0;
  assign iss_tag    = TAG_W'(rsv_pkg::slot_tag(32'(pick_idx)));

  genvar gs;
  generate
    for (gs = 0; gs < N_ENT; gs++) begin : g_slot
      rsv_entry #(.OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) ent_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (alloc_oh[gs]),
        .release_i (grant_oh[gs]),
        .in_op     (iss_op),
        .in_vj     (iss_vj),
        .in_qj     (iss_qj),
        .in_vk     (iss_vk),
        .in_qk     (iss_qk),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value),
        .busy      (busy_vec[gs]),
        .ready     (ready_vec[gs]),
        .op        (op_a[gs]),
        .vj        (vj_a[gs]),
        .vk        (vk_a[gs]),
        .qj        (qj_a[gs]),
        .qk        (qk_a[gs])
      );
      assign qj_flat[gs*TAG_W +: TAG_W] = qj_a[gs];
      assign qk_flat[gs*TAG_W +: TAG_W] = qk_a[gs];
    end
  endgenerate

  rsv_age_sel #(.N_ENT(N_ENT)) sel_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_oh    (alloc_oh),
    .busy_vec    (busy_vec),
    .ready_vec   (ready_vec),
    .grant_valid (dsp_valid),
    .grant_oh    (grant_oh),
    .grant_idx   (grant_idx)
  );

  assign dsp_op  = op_a[grant_idx];
  assign dsp_vj  = vj_a[grant_idx];
  assign dsp_vk  = vk_a[grant_idx];
  assign dsp_tag = TAG_W'(rsv_pkg::slot_tag(32'(grant_idx)));

endmodule

// File: rtl/rsv_bank_chk.sv
module rsv_bank_chk #(
  parameter int unsigned N_ENT  = 4,
  parameter int unsigned TAG_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   iss_full,
  input logic                   cdb_valid,
  input logic [TAG_W-1:0]       cdb_tag,
  input logic [N_ENT-1:0]       busy_vec,
  input logic [N_ENT-1:0]       grant_oh,
  input logic [N_ENT*TAG_W-1:0] qj_flat,
  input logic [N_ENT*TAG_W-1:0] qk_flat,
  input logic                   dsp_valid,
  input logic [TAG_W-1:0]       dsp_tag
);

  function automatic logic still_waits(input logic [N_ENT*TAG_W-1:0] qf,
                                       input logic [N_ENT-1:0]       bz,
                                       input logic [TAG_W-1:0]       t);
    logic found;
    found = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (bz[i] && qf[i*TAG_W +: TAG_W] == t) found = 1'b1;
    end
    return found;
  endfunction

  // R4: full is raised only when every slot holds an instruction.
  p_full_all_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_full |-> ($countones(busy_vec) == N_ENT));

  // R7: at most one entry granted per cycle.
  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh));

  // R6: a dispatch always comes from an occupied slot.
  p_grant_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> ((grant_oh & busy_vec) != '0));

  // R9: the granted slot is free after the edge.
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |=> ((busy_vec & $past(grant_oh)) == '0));

  // R5 and R8: nobody still waits on a tag broadcast at the previous edge.
  p_wakeup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && cdb_tag != '0) |=>
      (!still_waits(qj_flat, busy_vec, $past(cdb_tag)) &&
       !still_waits(qk_flat, busy_vec, $past(cdb_tag))));

  // R2: dispatched tags are slot tags, never zero.
  p_tag_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> (dsp_tag != '0 && 32'(dsp_tag) <= N_ENT));

endmodule

bind rsv_bank rsv_bank_chk #(.N_ENT(N_ENT), .TAG_W(TAG_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_full  (iss_full),
  .cdb_valid (cdb_valid),
  .cdb_tag   (cdb_tag),
  .busy_vec  (busy_vec),
  .grant_oh  (grant_oh),
  .qj_flat   (qj_flat),
  .qk_flat   (qk_flat),
  .dsp_valid (dsp_valid),
  .dsp_tag   (dsp_tag)
);

// File: tb/rsv_bank_tb_top.sv
module rsv_bank_tb_top;

  localparam int unsigned N_ENT = 4;
  localparam int unsigned OP_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned TAG_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              iss_valid = 1'b0;
  logic [OP_W-1:0]   iss_op = '0;
  logic [DATA_W-1:0] iss_vj = '0;
  logic [TAG_W-1:0]  iss_qj = '0;
  logic [DATA_W-1:0] iss_vk = '0;
  logic [TAG_W-1:0]  iss_qk = '0;
  logic              iss_full;
  logic [TAG_W-1:0]  iss_tag;
  logic              cdb_valid = 1'b0;
  logic [TAG_W-1:0]  cdb_tag = '0;
  logic [DATA_W-1:0] cdb_value = '0;
  logic              dsp_valid;
  logic [OP_W-1:0]   dsp_op;
  logic [DATA_W-1:0] dsp_vj;
  logic [DATA_W-1:0] dsp_vk;
  logic [TAG_W-1:0]  dsp_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rsv_bank #(.N_ENT(N_ENT), .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_vj(iss_vj), .iss_qj(iss_qj),
    .iss_vk(iss_vk), .iss_qk(iss_qk), .iss_full(iss_full), .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_vj(dsp_vj), .dsp_vk(dsp_vk),
    .dsp_tag(dsp_tag)
  );

  typedef struct packed {
    logic        iv;
    logic [3:0]  op;
    logic [15:0] vj;
    logic [3:0]  qj;
    logic [15:0] vk;
    logic [3:0]  qk;
    logic        cv;
    logic [3:0]  ct;
    logic [15:0] cval;
    logic        ev;
    logic [3:0]  eop;
    logic [3:0]  etag;
    logic [15:0] evj;
    logic [15:0] evk;
    logic        efull;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    // R3: ready issue dispatches next cycle from slot tag 1
    '{1'b1, 4'd1, 16'h0011, 4'd0, 16'h0022, 4'd0, 1'b0, 4'd0, 16'h0000,
      1'b1, 4'd1, 4'd1, 16'h0011, 16'h0022, 1'b0, 4'd3},
    // R9: slot freed, nothing left
    '{1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd0, 1'b0, 4'd0, 16'h0000,
      1'b0, 4'd0, 4'd0, 16'h0000, 16'h0000, 1'b0, 4'd9},
    // R6: first operand waits on tag 9
    '{1'b1, 4'd2, 16'hDEAD, 4'd9, 16'h0033, 4'd0, 1'b0, 4'd0, 16'h0000,
      1'b0, 4'd0, 4'd0, 16'h0000, 16'h0000, 1'b0, 4'd6},
    // R6: second operand waits on tag 10
    '{1'b1, 4'd3, 16'h0044, 4'd0, 16'hBEEF, 4'd10, 1'b0, 4'd0, 16'h0000,
      1'b0, 4'd0, 4'd0, 16'h0000, 16'h0000, 1'b0, 4'd6},
    // R5: broadcast tag 9 wakes tag 1
    '{1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd0, 1'b1, 4'd9, 16'h0055,
      1'b1, 4'd2, 4'd1, 16'h0055, 16'h0033, 1'b0, 4'd5},
    // R5: broadcast tag 10 wakes tag 2
    '{1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd0, 1'b1, 4'd10, 16'h0066,
      1'b1, 4'd3, 4'd2, 16'h0044, 16'h0066, 1'b0, 4'd5},
    // R9
    '{1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd0, 1'b0, 4'd0, 16'h0000,
      1'b0, 4'd0, 4'd0, 16'h0000, 16'h0000, 1'b0, 4'd9},
    // R8: issue waiting on 11 while 11 is broadcast
    '{1'b1, 4'd4, 16'hDEAD, 4'd11, 16'h0077, 4'd0, 1'b1, 4'd11, 16'h0088,
      1'b1, 4'd4, 4'd1, 16'h0088, 16'h0077, 1'b0, 4'd8},
    // R9
    '{1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd0, 1'b0, 4'd0, 16'h0000,
      1'b0, 4'd0, 4'd0, 16'h0000, 16'h0000, 1'b0, 4'd9}
  };

  task automatic drive(input logic iv, input logic [3:0] op, input logic [15:0] vj,
                       input logic [3:0] qj, input logic [15:0] vk, input logic [3:0] qk,
                       input logic cv, input logic [3:0] ct, input logic [15:0] cval);
    @(negedge clk);
    iss_valid = iv; iss_op = op; iss_vj = vj; iss_qj = qj;
    iss_vk = vk; iss_qk = qk;
    cdb_valid = cv; cdb_tag = ct; cdb_value = cval;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 4'd0, 16'h0, 4'd0, 16'h0, 4'd0, 1'b0, 4'd0, 16'h0);
  endtask

  task automatic chk_dsp(input string req, input logic ev, input logic [3:0] eop,
                         input logic [3:0] etag, input logic [15:0] evj,
                         input logic [15:0] evk);
    n_chk++;
    if (ev) begin
      if (!(dsp_valid === 1'b1 && dsp_op === eop && dsp_tag === etag &&
            dsp_vj === evj && dsp_vk === evk)) begin
        n_bad++;
        $display("FAIL %s dispatch: got v=%0b op=%0h tag=%0h vj=%0h vk=%0h exp v=1 op=%0h tag=%0h vj=%0h vk=%0h",
                 req, dsp_valid, dsp_op, dsp_tag, dsp_vj, dsp_vk, eop, etag, evj, evk);
      end
    end else if (dsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s dispatch: got v=%0b tag=%0h exp v=0", req, dsp_valid, dsp_tag);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic got,
                         input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b exp %0b", req, what, got, exp);
    end
  endtask

  task automatic chk_tag(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s iss_tag: got %0h exp %0h", req, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk_bit("R1", "iss_full", iss_full, 1'b0);
    chk_dsp("R1", 1'b0, 4'd0, 4'd0, 16'h0, 16'h0);
    chk_tag("R1", iss_tag, 4'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      drive(TBL[k].iv, TBL[k].op, TBL[k].vj, TBL[k].qj, TBL[k].vk, TBL[k].qk,
            TBL[k].cv, TBL[k].ct, TBL[k].cval);
      chk_dsp($sformatf("R%0d row%0d", TBL[k].req, k), TBL[k].ev, TBL[k].eop,
              TBL[k].etag, TBL[k].evj, TBL[k].evk);
      chk_bit($sformatf("R%0d row%0d", TBL[k].req, k), "iss_full", iss_full, TBL[k].efull);
    end

    // Directed: fill, full, ignored broadcasts, oldest-first.
    chk_tag("R2", iss_tag, 4'd1);
    drive(1'b1, 4'd5, 16'h0, 4'd12, 16'h00A1, 4'd0, 1'b0, 4'd0, 16'h0);
    chk_tag("R2", iss_tag, 4'd2);
    drive(1'b1, 4'd5, 16'h0, 4'd13, 16'h00A2, 4'd0, 1'b0, 4'd0, 16'h0);
    drive(1'b1, 4'd5, 16'h0, 4'd12, 16'h00A3, 4'd0, 1'b0, 4'd0, 16'h0);
    drive(1'b1, 4'd5, 16'h0, 4'd12, 16'h00A4, 4'd0, 1'b0, 4'd0, 16'h0);
    chk_bit("R4", "iss_full", iss_full, 1'b1);
    chk_dsp("R6", 1'b0, 4'd0, 4'd0, 16'h0, 16'h0);
    // R4: ready instruction offered while full is dropped
    drive(1'b1, 4'd7, 16'h0BAD, 4'd0, 16'h0BAD, 4'd0, 1'b0, 4'd0, 16'h0);
    chk_dsp("R4", 1'b0, 4'd0, 4'd0, 16'h0, 16'h0);
    chk_bit("R4", "iss_full", iss_full, 1'b1);
    // R10: tag zero broadcast changes nothing
    drive(1'b0, 4'd0, 16'h0, 4'd0, 16'h0, 4'd0, 1'b1, 4'd0, 16'h00EE);
    chk_dsp("R10", 1'b0, 4'd0, 4'd0, 16'h0, 16'h0);
    // R11: unmatched tag changes nothing
    drive(1'b0, 4'd0, 16'h0, 4'd0, 16'h0, 4'd0, 1'b1, 4'd7, 16'h00EF);
    chk_dsp("R11", 1'b0, 4'd0, 4'd0, 16'h0, 16'h0);
    // R5: tag 13 releases slot tag 2
    drive(1'b0, 4'd0, 16'h0, 4'd0, 16'h0, 4'd0, 1'b1, 4'd13, 16'h00B0);
    chk_dsp("R5", 1'b1, 4'd5, 4'd2, 16'h00B0, 16'h00A2);
    idle();
    // R9: freed slot is the one offered next
    chk_bit("R9", "iss_full", iss_full, 1'b0);
    chk_tag("R9", iss_tag, 4'd2);
    drive(1'b1, 4'd6, 16'h0, 4'd12, 16'h00A5, 4'd0, 1'b0, 4'd0, 16'h0);
    chk_dsp("R6", 1'b0, 4'd0, 4'd0, 16'h0, 16'h0);
    // R7: one broadcast readies four; order follows issue: 1,3,4,2
    drive(1'b0, 4'd0, 16'h0, 4'd0, 16'h0, 4'd0, 1'b1, 4'd12, 16'h00C0);
    chk_dsp("R7", 1'b1, 4'd5, 4'd1, 16'h00C0, 16'h00A1);
    idle();
    chk_dsp("R7", 1'b1, 4'd5, 4'd3, 16'h00C0, 16'h00A3);
    idle();
    chk_dsp("R7", 1'b1, 4'd5, 4'd4, 16'h00C0, 16'h00A4);
    idle();
    chk_dsp("R7", 1'b1, 4'd6, 4'd2, 16'h00C0, 16'h00A5);
    idle();
    chk_dsp("R7", 1'b0, 4'd0, 4'd0, 16'h0, 16'h0);
    chk_bit("R9", "iss_full", iss_full, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule